// File: doc/BRIEF.md
# Capture/Reload/Baud 16-bit Timer

This block is a 16-bit up-counting timer with three modes of operation, all sharing one counter. The counter advances on an internal tick (timer mode) or on falling edges of an external count pin (counter mode). A second external pin serves as a trigger. Depending on the mode, a trigger event either snapshots the count into a holding register pair or forces the count back to a preset value.

Two configuration bits select a bit-rate role for the counter. In that role it reloads itself on every wrap and emits a one-cycle pulse that a serial port's bit divider can consume. A byte-wide register bus gives software access to the configuration, the flags, the count bytes and the holding bytes. One interrupt line reports either flag.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every register reads 0x00, and `irq` and `baud_pulse` are low.
- R2: While the run bit is 0, the count does not advance, whatever `tick` or `cnt_pin` do.
- R3: In timer mode (count-source bit 0) with run set, each cycle with `tick` high adds one to the count. The high byte steps only when the low byte wraps from 0xFF to 0x00.
- R4: In counter mode (count-source bit 1), `tick` is ignored. Each falling edge on `cnt_pin` adds exactly one, however long the pin then stays low. The input passes through a two-flop synchronizer, and the count reflects an edge by the third rising clock edge after the pin falls.
- R5: If either the receive-rate bit or the transmit-rate bit is set, the block is in bit-rate mode, whatever the capture-select bit says. Otherwise, capture-select 1 gives capture mode and 0 gives reload mode.
- R6: In capture mode, a count wrap from 0xFFFF sets the overflow flag, and counting continues from 0x0000.
- R7: In capture mode, a falling edge on `trig_pin` with the trigger-enable bit set copies the count into the holding pair and sets the trigger flag, leaving the count unchanged. With trigger-enable clear, the edge changes nothing.
- R8: In reload mode, a count wrap loads the count from the holding pair and sets the overflow flag.
- R9: In reload mode, an enabled trigger edge loads the count from the holding pair and sets the trigger flag.
- R10: In bit-rate mode, a wrap loads the count from the holding pair, leaves the overflow flag untouched, and raises `baud_pulse` for exactly one cycle.
- R11: In bit-rate mode, an enabled trigger edge sets the trigger flag and does not alter the count.
- R12: `irq` is high exactly when the overflow flag or the trigger flag is set. Both flags stay set until software writes the control register. A hardware set in the same cycle as that write wins.
- R13: Register map, with `bus_rdata` combinational on `bus_addr` and unused addresses reading 0x00:
  - 0: control. The bits are run (bit 0), count-source (bit 1), capture-select (bit 2), trigger-enable (bit 3), receive-rate (bit 4), transmit-rate (bit 5), overflow flag (bit 6) and trigger flag (bit 7).
  - 1: count low byte; 2: count high byte.
  - 3: holding low byte; 4: holding high byte.
  - A bus write to a count byte overrides counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tick | input | 1 | Internal count enable, one count per high cycle |
| cnt_pin | input | 1 | External count input (asynchronous) |
| trig_pin | input | 1 | External trigger input (asynchronous) |
| irq | output | 1 | Interrupt request |
| baud_pulse | output | 1 | One-cycle pulse on each wrap in bit-rate mode |

## Verification
On every cycle, the assertions check the following:
- a detected edge lasts only one cycle;
- the count holds while the block is stopped;
- the overflow flag never rises in bit-rate mode;
- `baud_pulse` only follows a bit-rate wrap;
- a capture copies the exact pre-edge count;
- `irq` rises only after a flag-setting event or a control write.

Only the bench's scenarios can show the following:
- the arithmetic of carries across the byte boundary;
- the reload values after a wrap or a trigger;
- that a disabled trigger or a held-low count pin leaves state alone;
- that flags persist until software clears them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    MODE_RELOAD  = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_BAUD    = 2'd2
  } mode_e;

  typedef struct packed {
    logic ext_flag;
    logic ovf_flag;
    logic tx_rate;
    logic rx_rate;
    logic trig_en;
    logic cap_sel;
    logic cnt_src;
    logic run;
  } ctrl_t;

  // Rate bits dominate; capture-select only matters outside bit-rate mode.
  function automatic mode_e pick_mode(ctrl_t c);
    if (c.rx_rate || c.tx_rate) return MODE_BAUD;
    if (c.cap_sel)              return MODE_CAPTURE;
    return MODE_RELOAD;
  endfunction

  function automatic logic [CNT_W-1:0] step_count(logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  function automatic logic at_top(logic [CNT_W-1:0] v);
    return &v;
  endfunction

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Reset to the idle-high level so no edge appears out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];

  // R4: each edge is reported for a single cycle only
  a_r4_fall_once: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cnt_src,
  input  logic              trig_en,
  input  mode_e             mode,
  input  logic              tick,
  input  logic              cnt_fall,
  input  logic              trig_fall,
  input  logic              wr_cnt_lo,
  input  logic              wr_cnt_hi,
  input  logic              wr_hold_lo,
  input  logic              wr_hold_hi,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  hold,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic              baud_pulse
);

  logic             inc_ev;
  logic             wrap_ev;
  logic             ext_ev;
  logic             capture_ev;
  logic             reload_ev;
  logic             baud_wrap;
  logic [CNT_W-1:0] count_n;
  logic [CNT_W-1:0] hold_n;
  logic             ovf_n;
  logic             ext_n;

  assign inc_ev     = run && (cnt_src ? cnt_fall : tick);
  assign wrap_ev    = inc_ev && at_top(count);
  assign ext_ev     = trig_fall && trig_en;
  assign capture_ev = (mode == MODE_CAPTURE) && ext_ev;
  assign reload_ev  = ((mode == MODE_RELOAD) && (wrap_ev || ext_ev)) ||
                      ((mode == MODE_BAUD) && wrap_ev);
  assign baud_wrap  = (mode == MODE_BAUD) && wrap_ev;

  always_comb begin
    count_n = count;
    if (reload_ev)   count_n = hold;
    else if (inc_ev) count_n = step_count(count);
    if (wr_cnt_lo) count_n[BYTE_W-1:0]     = wdata;
    if (wr_cnt_hi) count_n[CNT_W-1:BYTE_W] = wdata;
  end

  always_comb begin
    hold_n = hold;
    if (wr_hold_lo) hold_n[BYTE_W-1:0]     = wdata;
    if (wr_hold_hi) hold_n[CNT_W-1:BYTE_W] = wdata;
    if (capture_ev) hold_n = count;
  end

  always_comb begin
    ovf_n = wr_ctrl ? wdata[6] : ovf_flag;
    ext_n = wr_ctrl ? wdata[7] : ext_flag;
    if (wrap_ev && mode != MODE_BAUD) ovf_n = 1'b1;
    if (ext_ev)                       ext_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      hold       <= '0;
      ovf_flag   <= 1'b0;
      ext_flag   <= 1'b0;
      baud_pulse <= 1'b0;
    end else begin
      count      <= count_n;
      hold       <= hold_n;
      ovf_flag   <= ovf_n;
      ext_flag   <= ext_n;
      baud_pulse <= baud_wrap;
    end
  end

  // R2: a stopped timer keeps its count unless software or a reload moves it
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt_lo && !wr_cnt_hi && !reload_ev) |=> $stable(count));

  // R10: the overflow flag never rises while in bit-rate mode
  a_r10_no_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BAUD && !ovf_flag && !wr_ctrl) |=> !ovf_flag);

  // R10: the rate pulse only follows a bit-rate wrap
  a_r10_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(baud_pulse) |-> $past(mode == MODE_BAUD && wrap_ev));

  // R7: a capture stores the count as it stood before the edge
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture_ev |=> hold == $past(count));

  // R12: a flag only rises on its event or a control write
  a_r12_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag) || $rose(ext_flag)) |-> $past(wrap_ev || ext_ev || wr_ctrl));

endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  output logic              irq,
  output logic              baud_pulse
);

  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT_LO  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CNT_HI  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HOLD_LO = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_HOLD_HI = ADDR_W'(4);
  localparam int                CFG_W     = 6;

  logic [CFG_W-1:0] cfg_q;
  logic             ovf_flag, ext_flag;
  logic             cnt_fall, trig_fall;
  logic [CNT_W-1:0] count, hold;
  ctrl_t            ctrl_v;
  mode_e            mode;
  logic             wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_hold_lo, wr_hold_hi;

  assign wr_ctrl    = bus_wr && bus_addr == A_CTRL;
  assign wr_cnt_lo  = bus_wr && bus_addr == A_CNT_LO;
  assign wr_cnt_hi  = bus_wr && bus_addr == A_CNT_HI;
  assign wr_hold_lo = bus_wr && bus_addr == A_HOLD_LO;
  assign wr_hold_hi = bus_wr && bus_addr == A_HOLD_HI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (wr_ctrl) cfg_q <= bus_wdata[CFG_W-1:0];
  end

  assign ctrl_v = ctrl_t'({ext_flag, ovf_flag, cfg_q});
  assign mode   = pick_mode(ctrl_v);

  tmr_edge_det #(.STAGES(SYNC_STAGES)) u_cnt_edge (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(cnt_fall)
  );

  tmr_edge_det #(.STAGES(SYNC_STAGES)) u_trig_edge (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall(trig_fall)
  );

  tmr_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl_v.run),
    .cnt_src    (ctrl_v.cnt_src),
    .trig_en    (ctrl_v.trig_en),
    .mode       (mode),
    .tick       (tick),
    .cnt_fall   (cnt_fall),
    .trig_fall  (trig_fall),
    .wr_cnt_lo  (wr_cnt_lo),
    .wr_cnt_hi  (wr_cnt_hi),
    .wr_hold_lo (wr_hold_lo),
    .wr_hold_hi (wr_hold_hi),
    .wr_ctrl    (wr_ctrl),
    .wdata      (bus_wdata),
    .count      (count),
    .hold       (hold),
    .ovf_flag   (ovf_flag),
    .ext_flag   (ext_flag),
    .baud_pulse (baud_pulse)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:    bus_rdata = ctrl_v;
      A_CNT_LO:  bus_rdata = count[BYTE_W-1:0];
      A_CNT_HI:  bus_rdata = count[CNT_W-1:BYTE_W];
      A_HOLD_LO: bus_rdata = hold[BYTE_W-1:0];
      A_HOLD_HI: bus_rdata = hold[CNT_W-1:BYTE_W];
      default:   bus_rdata = 8'h00;
    endcase
  end

  assign irq = ovf_flag | ext_flag;

  // R12: a request appears only after a flag event or a control write
  a_r12_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_ctrl || cnt_fall || tick || trig_fall));

endmodule

// File: tb/cap_reload_timer_test.sv
module cap_reload_timer_test;

  localparam int ADDR_W = 3;
  localparam logic [7:0] RUN = 8'h01, CSRC = 8'h02, CAP = 8'h04, TEN = 8'h08;
  localparam logic [7:0] RXR = 8'h10, TXR = 8'h20, OVF = 8'h40, EXF = 8'h80;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;
  logic              tick = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1;
  logic              irq, baud_pulse;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [7:0]        value;
    string             tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  cap_reload_timer #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .cnt_pin(cnt_pin), .trig_pin(trig_pin), .irq(irq), .baud_pulse(baud_pulse)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected register values and compares against reads.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        bus_addr = it.addr;
        #1;
        check(it.tag, bus_rdata, it.value);
      end
    end
  end

  always @(negedge clk) if (rst_n && baud_pulse) pulses++;

  task automatic expect_reg(int a, logic [7:0] v, string tag);
    exp_t it;
    it.addr = ADDR_W'(a);
    it.value = v;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [7:0] d);
    drain();
    bus_addr = ADDR_W'(a);
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pin_fall(bit which_trig);
    @(negedge clk);
    if (which_trig) trig_pin = 1'b0; else cnt_pin = 1'b0;
    repeat (5) @(negedge clk);
    if (which_trig) trig_pin = 1'b1; else cnt_pin = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic expect_count(logic [15:0] v, string tag);
    expect_reg(1, v[7:0], tag);
    expect_reg(2, v[15:8], tag);
  endtask

  task automatic expect_hold(logic [15:0] v, string tag);
    expect_reg(3, v[7:0], tag);
    expect_reg(4, v[15:8], tag);
  endtask

  task automatic set_count(logic [15:0] v);
    wr(1, v[7:0]);
    wr(2, v[15:8]);
  endtask

  task automatic set_hold(logic [15:0] v);
    wr(3, v[7:0]);
    wr(4, v[15:8]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_reg(0, 8'h00, "R1 ctrl");
    expect_count(16'h0000, "R1 count");
    expect_hold(16'h0000, "R1 hold");
    drain();
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 baud_pulse", {7'd0, baud_pulse}, 8'h00);

    // R2 stopped: tick held high, count stays
    tick = 1'b1;
    repeat (10) @(negedge clk);
    tick = 1'b0;
    expect_count(16'h0000, "R2 stopped");

    // R3 timer mode, carry into high byte; R13 unused address
    set_count(16'h00FE);
    wr(0, RUN);
    repeat (3) tick_once();
    expect_count(16'h0101, "R3 carry");
    expect_reg(0, RUN, "R3 no flag");
    expect_reg(6, 8'h00, "R13 unused address");
    wr(0, 8'h00);

    // R6 capture overflow
    set_count(16'hFFFE);
    wr(0, RUN | CAP);
    repeat (3) tick_once();
    expect_count(16'h0001, "R6 wrap continues");
    expect_reg(0, RUN | CAP | OVF, "R6 overflow flag");
    drain();
    check("R12 irq on ovf", {7'd0, irq}, 8'h01);
    repeat (10) @(negedge clk);
    expect_reg(0, RUN | CAP | OVF, "R12 flag persists");
    wr(0, RUN | CAP);
    drain();
    check("R12 irq cleared", {7'd0, irq}, 8'h00);

    // R7 capture trigger, disabled then enabled
    set_count(16'h1234);
    pin_fall(1'b1);
    expect_hold(16'h0000, "R7 disabled trigger");
    expect_reg(0, RUN | CAP, "R7 disabled no flag");
    wr(0, RUN | CAP | TEN);
    pin_fall(1'b1);
    expect_hold(16'h1234, "R7 captured");
    expect_count(16'h1234, "R7 count kept");
    expect_reg(0, RUN | CAP | TEN | EXF, "R7 trigger flag");
    drain();
    check("R12 irq on ext", {7'd0, irq}, 8'h01);
    wr(0, 8'h00);

    // R8 reload on wrap
    set_hold(16'hABCD);
    set_count(16'hFFFF);
    wr(0, RUN);
    tick_once();
    expect_count(16'hABCD, "R8 reload on wrap");
    expect_reg(0, RUN | OVF, "R8 overflow flag");
    // R9 reload on trigger
    set_count(16'h0005);
    wr(0, RUN | TEN);
    pin_fall(1'b1);
    expect_count(16'hABCD, "R9 reload on trigger");
    expect_reg(0, RUN | TEN | EXF, "R9 trigger flag");
    wr(0, 8'h00);

    // R4 counter mode: tick ignored, one count per edge held low
    set_count(16'h0000);
    wr(0, RUN | CSRC);
    tick = 1'b1;
    for (int i = 0; i < 4; i++) pin_fall(1'b0);
    tick = 1'b0;
    expect_count(16'h0004, "R4 edges counted");
    wr(0, 8'h00);

    // R5/R10 bit-rate mode beats capture-select
    set_hold(16'hFF00);
    set_count(16'hFFFF);
    wr(0, RUN | TXR | CAP);
    drain();
    check("R10 no pulse before", pulses[7:0], 8'd0);
    tick_once();
    expect_count(16'hFF00, "R5 R10 reload in bit-rate");
    expect_reg(0, RUN | TXR | CAP, "R10 no overflow flag");
    expect_hold(16'hFF00, "R5 hold untouched");
    drain();
    check("R10 single pulse", pulses[7:0], 8'd1);

    // R11 trigger in bit-rate mode
    wr(0, RUN | RXR | TEN);
    set_count(16'h0010);
    pin_fall(1'b1);
    expect_count(16'h0010, "R11 count untouched");
    expect_reg(0, RUN | RXR | TEN | EXF, "R11 trigger flag");
    drain();
    check("R11 irq", {7'd0, irq}, 8'h01);
    wr(0, 8'h00);
    drain();
    check("R12 irq after clear", {7'd0, irq}, 8'h00);
    check("R10 pulse total", pulses[7:0], 8'd1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(negedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule